// File: doc/BRIEF.md
# Bipolar line code decoder

This block turns a pair of receive rails into one NRZ data stream and one error strobe. Both rails are sampled on the recovered clock: one rail carries positive pulses and the other carries negative pulses. It serves one channel. It runs in one of three line codes: plain alternate mark inversion, the four-zero substitution code used on E1 links (HDB3), or the eight-zero substitution code used on T1 links (B8ZS).

In the two substitution codes, a legal substitution pattern is turned back into zeros. Any bipolar violation that is not part of a legal pattern raises the error strobe. In AMI, every violation raises it. In HDB3 only, a run of too many zeros also raises it. The decoder keeps the last eight symbols in a delay line, so a pattern can be confirmed before its first symbol leaves. Decoded output therefore lags the input by the same number of cycles in every code.

When decoding is disabled, the two rails go straight to the two outputs. A shared edge-select input decides whether the outputs change on the rising or the falling clock edge.

Top module: `bipolar_decoder`

## Requirements
- R1: While reset is high, and at the first sample after reset, both outputs are 0.
- R2: With decode enable low, the positive rail appears on `data_o` and the negative rail on `lcv_o` one clock edge after it is sampled. There is no decoding and no error check.
- R3: With code select 0 (AMI; value 3 behaves the same), every mark on either rail gives a 1 and every space gives a 0. A mark with the same polarity as the previous single-rail mark raises `lcv_o`.
- R4: With code select 1 (HDB3), a violation preceded by three spaces (000V) is output as four zeros with no error. So is a violation preceded by a normal mark and two spaces (B00V).
- R5: In HDB3, a violation that fits neither substitution form is output as a 1 with `lcv_o` high.
- R6: With code select 2 (B8ZS), the sequence 0,0,0,V,B,0,V,B is output as eight zeros with no error. Here V repeats the polarity of the previous mark and B alternates.
- R7: In B8ZS, a violation that is not part of a complete eight-symbol pattern is output as a 1 with `lcv_o` high.
- R8: In HDB3 only, the fourth consecutive space of a run raises `lcv_o`. This happens once per run. Longer runs are not flagged again, and AMI and B8ZS never flag zero runs.
- R9: A symbol with both rails high is output as a 1 with `lcv_o` high. It does not change the polarity reference used to detect the next violation.
- R10: Each error is reported as a one-cycle `lcv_o` pulse. The pulse is aligned with the output cycle of the offending symbol.
- R11: With edge select 0, the outputs change just after the rising edge. With edge select 1, they change just after the following falling edge.
- R12: With decoding enabled, a symbol sampled at rising edge k appears at the outputs after rising edge k+8. This latency is the same in all three codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_en_i | input | 1 | 1: decode to single rail; 0: pass rails through |
| code_mode_i | input | 2 | 0 AMI, 1 HDB3, 2 B8ZS, 3 AMI |
| fall_edge_i | input | 1 | 1: outputs change on falling edge; 0: rising edge |
| pos_i | input | 1 | Positive-pulse rail |
| neg_i | input | 1 | Negative-pulse rail |
| data_o | output | 1 | NRZ data (or positive rail in pass-through) |
| lcv_o | output | 1 | Line code violation strobe (or negative rail in pass-through) |

## Verification
If the polarity reference is wrong, clean streams show spurious `lcv_o` pulses. They appear within nine edges of the first mark that follows the fault. If a substitution is recognised with the wrong shape or at the wrong offset, the affected eight-symbol window shows stray ones or missing zeros, again nine edges later. If the zero-run counter is wrong, a flag appears at the wrong position, or too many flags appear, in a long HDB3 space run. The bench encodes long pseudo-random data in each code with its own encoder and expects the original bits back with no errors. It also drives short hand-built streams whose error positions are known.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

    typedef enum logic [1:0] {
        MODE_AMI  = 2'd0,
        MODE_HDB3 = 2'd1,
        MODE_B8ZS = 2'd2,
        MODE_ALT  = 2'd3
    } code_mode_e;

    // one received symbol as it travels down the delay line
    typedef struct packed {
        logic mk;   // a pulse was present
        logic bv;   // pulse repeats the previous polarity
        logic er;   // both rails high at once
        logic ex;   // fourth space of an E1 zero run
    } sym_t;

    localparam sym_t SYM_ZERO = '0;

    localparam int PATTERN_SPAN = 8;

    function automatic logic sym_flag(sym_t s);
        return s.bv | s.er | s.ex;
    endfunction

    function automatic logic is_space(sym_t s);
        return ~s.mk;
    endfunction

    function automatic logic is_plain_mark(sym_t s);
        return s.mk & ~s.bv & ~s.er;
    endfunction

    function automatic logic is_viol_mark(sym_t s);
        return s.mk & s.bv & ~s.er;
    endfunction

    function automatic sym_t absorb(sym_t s);
        sym_t r;
        r    = s;
        r.mk = 1'b0;
        r.bv = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/bpd_classify.sv
module bpd_classify
    import bpd_pkg::*;
#(
    parameter int EXZ_RUN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  code_mode_e mode_i,
    input  logic       pos_i,
    input  logic       neg_i,
    output sym_t       sym_o
);

    localparam int ZW = $clog2(EXZ_RUN + 1);

    logic          last_neg_q;
    logic          seen_q;
    logic [ZW-1:0] zrun_q;
    logic          mark;
    logic          dual;

    always_comb begin
        mark  = pos_i | neg_i;
        dual  = pos_i & neg_i;
        sym_o = SYM_ZERO;
        if (en_i) begin
            sym_o.mk = mark;
            sym_o.er = dual;
            sym_o.bv = mark & ~dual & seen_q & (neg_i == last_neg_q);
            sym_o.ex = ~mark & (mode_i == MODE_HDB3) & (zrun_q == ZW'(EXZ_RUN - 1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_neg_q <= 1'b0;
            seen_q     <= 1'b0;
            zrun_q     <= '0;
        end else if (en_i) begin
            if (mark && !dual) begin
                last_neg_q <= neg_i;
                seen_q     <= 1'b1;
            end
            if (mark) begin
                zrun_q <= '0;
            end else if (zrun_q != ZW'(EXZ_RUN)) begin
                zrun_q <= zrun_q + 1'b1;
            end
        end
    end

    // R9: a dual-rail symbol leaves the polarity reference alone
    a_r9_dual_keeps_pol: assert property (@(posedge clk) disable iff (rst)
        (en_i && pos_i && neg_i) |=> (last_neg_q == $past(last_neg_q)));

    // R8: the zero-run counter never passes its saturation value
    a_r8_zrun_bounded: assert property (@(posedge clk) disable iff (rst)
        (zrun_q <= ZW'(EXZ_RUN)));

endmodule

// File: rtl/bpd_line.sv
module bpd_line
    import bpd_pkg::*;
#(
    parameter int DEPTH = PATTERN_SPAN
) (
    input  logic       clk,
    input  logic       rst,
    input  code_mode_e mode_i,
    input  sym_t       sym_i,
    output sym_t       tail_o
);

    sym_t line_q [DEPTH];
    sym_t nxt    [DEPTH];
    sym_t cur;
    logic hdb3_hit;
    logic b8zs_hit;

    always_comb begin
        hdb3_hit = (mode_i == MODE_HDB3)
                 & is_viol_mark(sym_i)
                 & is_space(line_q[0]) & is_space(line_q[1])
                 & (is_space(line_q[2]) | is_plain_mark(line_q[2]));

        b8zs_hit = (mode_i == MODE_B8ZS)
                 & is_plain_mark(sym_i)
                 & is_viol_mark(line_q[0])
                 & is_space(line_q[1])
                 & is_plain_mark(line_q[2])
                 & is_viol_mark(line_q[3])
                 & is_space(line_q[4]) & is_space(line_q[5]) & is_space(line_q[6]);

        cur = sym_i;
        for (int k = 1; k < DEPTH; k++) begin
            nxt[k] = line_q[k-1];
        end

        if (hdb3_hit) begin
            cur    = absorb(sym_i);
            nxt[3] = absorb(line_q[2]);
        end

        if (b8zs_hit) begin
            cur    = absorb(sym_i);
            nxt[1] = absorb(line_q[0]);
            nxt[3] = absorb(line_q[2]);
            nxt[4] = absorb(line_q[3]);
        end

        nxt[0] = cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) begin
                line_q[k] <= SYM_ZERO;
            end
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                line_q[k] <= nxt[k];
            end
        end
    end

    assign tail_o = line_q[DEPTH-1];

    // R3: outside the substitution codes a violation is never absorbed
    a_r3_ami_keeps_viol: assert property (@(posedge clk) disable iff (rst)
        ((mode_i != MODE_HDB3) && (mode_i != MODE_B8ZS) && sym_i.bv) |=> line_q[0].bv);

    // R8: a zero-run flag only ever rides on a space
    a_r8_exz_on_space: assert property (@(posedge clk) disable iff (rst)
        line_q[DEPTH-1].ex |-> !line_q[DEPTH-1].mk);

    // R9: a dual-rail symbol survives every substitution check
    a_r9_dual_not_absorbed: assert property (@(posedge clk) disable iff (rst)
        sym_i.er |=> (line_q[0].er && line_q[0].mk));

endmodule

// File: rtl/bpd_edge_out.sv
module bpd_edge_out (
    input  logic clk,
    input  logic rst,
    input  logic fall_i,
    input  logic d_i,
    input  logic l_i,
    output logic data_o,
    output logic lcv_o
);

    logic [1:0] rise_q;
    logic [1:0] fall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q <= 2'b00;
        end else begin
            rise_q <= {d_i, l_i};
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            fall_q <= 2'b00;
        end else begin
            fall_q <= rise_q;
        end
    end

    assign data_o = fall_i ? fall_q[1] : rise_q[1];
    assign lcv_o  = fall_i ? fall_q[0] : rise_q[0];

    // R11: at each rising edge the falling-edge copy has caught up with the rising stage
    a_r11_fall_copy: assert property (@(posedge clk) disable iff (rst)
        fall_i |-> ({data_o, lcv_o} == rise_q));

    // R11: in rising mode the outputs move with the rising-edge stage
    a_r11_rise_path: assert property (@(posedge clk) disable iff (rst)
        !fall_i |=> (fall_i || ({data_o, lcv_o} == {$past(d_i), $past(l_i)})));

endmodule

// File: rtl/bipolar_decoder.sv
module bipolar_decoder
    import bpd_pkg::*;
#(
    parameter int DEPTH   = PATTERN_SPAN,
    parameter int EXZ_RUN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dec_en_i,
    input  logic [1:0] code_mode_i,
    input  logic       fall_edge_i,
    input  logic       pos_i,
    input  logic       neg_i,
    output logic       data_o,
    output logic       lcv_o
);

    code_mode_e mode;
    sym_t       head;
    sym_t       tail;
    logic       d_sel;
    logic       l_sel;

    assign mode = code_mode_e'(code_mode_i);

    bpd_classify #(.EXZ_RUN(EXZ_RUN)) u_classify (
        .clk    (clk),
        .rst    (rst),
        .en_i   (dec_en_i),
        .mode_i (mode),
        .pos_i  (pos_i),
        .neg_i  (neg_i),
        .sym_o  (head)
    );

    bpd_line #(.DEPTH(DEPTH)) u_line (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode),
        .sym_i  (head),
        .tail_o (tail)
    );

    always_comb begin
        if (dec_en_i) begin
            d_sel = tail.mk;
            l_sel = sym_flag(tail);
        end else begin
            d_sel = pos_i;
            l_sel = neg_i;
        end
    end

    bpd_edge_out u_out (
        .clk    (clk),
        .rst    (rst),
        .fall_i (fall_edge_i),
        .d_i    (d_sel),
        .l_i    (l_sel),
        .data_o (data_o),
        .lcv_o  (lcv_o)
    );

    // R2: in pass-through the rails reach the outputs one edge later
    a_r2_passthru: assert property (@(posedge clk) disable iff (rst)
        (!dec_en_i) |=> (fall_edge_i || (data_o == $past(pos_i) && lcv_o == $past(neg_i))));

endmodule

// File: tb/test_bipolar_decoder.sv
module test_bipolar_decoder;

    localparam int CLK_PER = 10;
    localparam int MAXN    = 600;
    localparam int LAT_DEC = 9;
    localparam int LAT_PT  = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_en = 1'b1;
    logic [1:0] mode = 2'd0;
    logic       fall = 1'b0;
    logic       pos = 1'b0;
    logic       neg = 1'b0;
    logic       data_o;
    logic       lcv_o;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    logic sp [MAXN];
    logic sn [MAXN];
    logic ed [MAXN];
    logic el [MAXN];
    int   n;
    logic [15:0] lf;

    bipolar_decoder i_bipolar_decoder (
        .clk         (clk),
        .rst         (rst),
        .dec_en_i    (dec_en),
        .code_mode_i (mode),
        .fall_edge_i (fall),
        .pos_i       (pos),
        .neg_i       (neg),
        .data_o      (data_o),
        .lcv_o       (lcv_o)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic check(input string req, input int idx,
                         input logic ad, input logic al, input logic xd, input logic xl);
        total++;
        if (ad !== xd || al !== xl) begin
            bad++;
            $display("FAIL %s idx=%0d data=%b lcv=%b expected data=%b lcv=%b",
                     req, idx, ad, al, xd, xl);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        pos = 1'b0;
        neg = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic put(input int i, input int code, input logic d, input logic l);
        sp[i] = (code == 1) || (code == 3);
        sn[i] = (code == 2) || (code == 3);
        ed[i] = d;
        el[i] = l;
    endtask

    task automatic mark_at(input int i, input logic negp);
        sp[i] = ~negp;
        sn[i] = negp;
    endtask

    task automatic run(input string req, input int lat);
        do_reset();
        for (int c = 0; c < n + lat; c++) begin
            @(posedge clk);
            #1;
            pos = (c < n) ? sp[c] : 1'b0;
            neg = (c < n) ? sn[c] : 1'b0;
            #(CLK_PER - 2);
            if (c - lat >= 0) begin
                check(req, c - lat, data_o, lcv_o, ed[c - lat], el[c - lat]);
            end
        end
    endtask

    task automatic gen_bits(input int len, input logic [15:0] seed);
        lf = seed;
        n  = len;
        for (int i = 0; i < len; i++) begin
            logic b;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            b  = lf[0];
            if ((i % 37) >= 20 && (i % 37) < 31) b = 1'b0;
            if (i == 0) b = 1'b1;
            ed[i] = b;
            el[i] = 1'b0;
            sp[i] = 1'b0;
            sn[i] = 1'b0;
        end
    endtask

    task automatic enc_ami();
        logic last = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (ed[i]) begin
                last = ~last;
                mark_at(i, last);
            end
        end
    endtask

    task automatic enc_hdb3();
        logic last = 1'b1;
        int zc = 0;
        int pc = 0;
        for (int i = 0; i < n; i++) begin
            if (ed[i]) begin
                last = ~last;
                mark_at(i, last);
                pc++;
                zc = 0;
            end else begin
                zc++;
                if (zc == 4) begin
                    if (pc % 2 == 1) begin
                        mark_at(i, last);
                    end else begin
                        last = ~last;
                        mark_at(i - 3, last);
                        mark_at(i, last);
                    end
                    pc = 0;
                    zc = 0;
                end
            end
        end
    endtask

    task automatic enc_b8zs();
        logic last = 1'b1;
        int zc = 0;
        for (int i = 0; i < n; i++) begin
            if (ed[i]) begin
                last = ~last;
                mark_at(i, last);
                zc = 0;
            end else begin
                zc++;
                if (zc == 8) begin
                    mark_at(i - 4, last);
                    mark_at(i - 3, ~last);
                    mark_at(i - 1, ~last);
                    mark_at(i, last);
                    zc = 0;
                end
            end
        end
    endtask

    initial begin
        #(CLK_PER * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R1 in reset", 0, data_o, lcv_o, 1'b0, 1'b0);
        rst = 1'b0;
        @(posedge clk);
        #1 check("R1 after reset", 1, data_o, lcv_o, 1'b0, 1'b0);

        for (int f = 0; f < 2; f++) begin
            fall   = f[0];
            dec_en = 1'b1;

            // R3 R12: clean AMI stream
            mode = 2'd0; gen_bits(400, 16'hACE1); enc_ami();
            run("R3 R12 AMI clean", LAT_DEC);
            // R3: code value 3 behaves as AMI
            mode = 2'd3; gen_bits(120, 16'h1234); enc_ami();
            run("R3 mode3 clean", LAT_DEC);
            // R4 R12: clean HDB3 stream, both substitution forms
            mode = 2'd1; gen_bits(400, 16'hBEEF); enc_hdb3();
            run("R4 R12 HDB3 clean", LAT_DEC);
            // R6 R12: clean B8ZS stream
            mode = 2'd2; gen_bits(400, 16'h5A5A); enc_b8zs();
            run("R6 R12 B8ZS clean", LAT_DEC);

            // R3 R10: AMI violations, each one pulse
            mode = 2'd0; n = 6;
            put(0,1,1,0); put(1,0,0,0); put(2,1,1,1); put(3,2,1,0); put(4,0,0,0); put(5,2,1,1);
            run("R3 R10 AMI violation", LAT_DEC);

            // R5: HDB3 violation with a mark too close
            mode = 2'd1; n = 4;
            put(0,1,1,0); put(1,0,0,0); put(2,1,1,1); put(3,2,1,0);
            run("R5 HDB3 bad violation", LAT_DEC);

            // R4: 000V after a mark
            mode = 2'd1; n = 6;
            put(0,1,1,0); put(1,0,0,0); put(2,0,0,0); put(3,0,0,0); put(4,1,0,0); put(5,2,1,0);
            run("R4 HDB3 000V", LAT_DEC);

            // R8: HDB3 long zero run flagged once at its fourth space
            mode = 2'd1; n = 8;
            put(0,1,1,0); put(1,0,0,0); put(2,0,0,0); put(3,0,0,0);
            put(4,0,0,1); put(5,0,0,0); put(6,0,0,0); put(7,2,1,0);
            run("R8 HDB3 zero run", LAT_DEC);
            // R8: the same run is not flagged in AMI or B8ZS
            mode = 2'd0; el[4] = 1'b0;
            run("R8 AMI zero run ignored", LAT_DEC);
            mode = 2'd2;
            run("R8 B8ZS zero run ignored", LAT_DEC);

            // R7: B8ZS violation outside a pattern
            mode = 2'd2; n = 6;
            put(0,1,1,0); put(1,0,0,0); put(2,0,0,0); put(3,0,0,0); put(4,1,1,1); put(5,2,1,0);
            run("R7 B8ZS stray violation", LAT_DEC);

            // R7: truncated eight-symbol pattern
            mode = 2'd2; n = 10;
            put(0,1,1,0); put(1,0,0,0); put(2,0,0,0); put(3,0,0,0); put(4,1,1,1);
            put(5,2,1,0); put(6,0,0,0); put(7,2,1,1); put(8,0,0,0); put(9,1,1,0);
            run("R7 B8ZS truncated pattern", LAT_DEC);

            // R9: dual-rail symbol, polarity reference kept
            mode = 2'd0; n = 5;
            put(0,1,1,0); put(1,3,1,1); put(2,2,1,0); put(3,0,0,0); put(4,1,1,0);
            run("R9 dual rail", LAT_DEC);

            // R2: pass-through of every rail pair
            dec_en = 1'b0; mode = 2'd1; gen_bits(64, 16'h0F0F);
            for (int i = 0; i < n; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                put(i, (i < 4) ? i : int'(lf[1:0]), 1'b0, 1'b0);
                ed[i] = sp[i];
                el[i] = sn[i];
            end
            run("R2 pass-through", LAT_PT);
        end

        // R11: which edge moves the outputs
        for (int f = 0; f < 2; f++) begin
            fall   = f[0];
            dec_en = 1'b0;
            do_reset();
            @(posedge clk);
            #1 pos = 1'b1;
            @(posedge clk);
            #1 check("R11 just after rising edge", f, data_o, lcv_o, (f == 0), 1'b0);
            pos = 1'b0;
            @(negedge clk);
            #1 check("R11 just after falling edge", f, data_o, lcv_o, 1'b1, 1'b0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule